// File: doc/BRIEF.md
# Serial Memory Bus Slave

This block is the bus-side logic of a small two-wire serial memory. It watches the clock and data lines through an oversampling system clock. A stability filter on each line removes short spikes. The block finds the bus start and stop events and answers a device byte that carries a fixed type code, three strap-selected bits and a direction bit. It then accepts a word address and data bytes, or streams bytes back to the master. It pulls the data line low through an open-drain enable: a 1 on `sda_oe` means the line is pulled low.

A write that stores at least one byte begins a timed internal programming period when the stop event arrives. While that period runs, the device byte is not acknowledged, so the master can poll for completion. A write-direction device byte and a word address, followed by a repeated start in the read direction, give a random read. A write-protect input keeps the storage unchanged and still acknowledges every byte.

Top module: `i2c_mem_slave`

## Requirements
- R1: A pulse on SCL or SDA that lasts fewer than FILT_LEN system clocks is ignored. A transfer that contains such pulses completes and stores the same bytes as a transfer without them.
- R2: A start event (SDA falls while SCL is high) is recognised in any state. It releases SDA and begins a new device-byte reception. A repeated start after a word address turns the transfer into a random read.
- R3: A stop event (SDA rises while SCL is high) releases SDA and returns the block to idle. SDA is released after reset.
- R4: The device byte is matched MSB first. Bits 7..4 must equal 1010, bits 3..1 must equal `dev_sel[2:0]`, and bit 0 gives the direction (0 write, 1 read). A mismatch is not acknowledged, and the block ignores the bus until the next start.
- R5: After a matching device byte, after the word address byte and after every write-data byte, the block pulls SDA low for the whole ninth SCL clock.
- R6: Each written byte is stored at the current address. The address then increments and wraps from MEM_DEPTH-1 to 0.
- R7: In a read, the block sends the byte at the current address MSB first, one bit per SCL low phase, and then increments the address. It sends the next byte while the master acknowledges. After a not-acknowledge it keeps SDA released until the next start or stop.
- R8: After a stop that ends a write which stored at least one byte, the device byte is not acknowledged for BUSY_CYCLES system clocks. After that period it is acknowledged again.
- R9: While `wp` is high, address and data bytes are still acknowledged. No location changes, and the following stop starts no busy period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| dev_sel | input | 3 | Strap bits compared with device byte bits 3..1 |
| wp | input | 1 | Write protect, high blocks storage updates |
| sda_oe | output | 1 | Pull data line low when 1 |

## Verification
The assertions assume that the master changes SDA only while SCL is low, except when it forms a start or stop event. They also assume that every real edge on either line stays stable for longer than the filter window, and that `wp` does not change inside a data byte. The bench moves SDA half a low phase after each SCL fall. It places its deliberate spikes of two system clocks inside an SCL high phase, and it changes the strap and protect inputs only between transfers. Under these conditions the filtered lines keep the order of their raw edges.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WADDR,
    ST_WDATA,
    ST_RD,
    ST_SKIP
  } slv_state_t;

  // device byte: type code, strap bits, direction bit
  function automatic logic dev_hit(input logic [7:0] b, input logic [2:0] sel);
    return (b[7:4] == DEV_CODE) && (b[3:1] == sel);
  endfunction

endpackage

// File: rtl/i2cm_glitch_filt.sv
module i2cm_glitch_filt #(
  parameter int LEN = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(LEN + 1);

  logic [1:0]    sync;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync <= 2'b11;
      dout <= 1'b1;
      cnt  <= '0;
    end else begin
      sync <= {sync[0], din};
      if (sync[1] == dout) begin
        cnt <= '0;
      end else if (cnt == CW'(LEN - 1)) begin
        dout <= sync[1];
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2cm_store.sv
module i2cm_store #(
  parameter int DEPTH = 64,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= 8'h00;
    end else if (we) begin
      cells[waddr] <= wdata;
    end
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave #(
  parameter int FILT_LEN    = 20,
  parameter int MEM_DEPTH   = 64,
  parameter int BUSY_CYCLES = 1000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] dev_sel,
  input  logic       wp,
  output logic       sda_oe
);
  import i2cm_pkg::*;

  localparam int AW = $clog2(MEM_DEPTH);
  localparam int BW = $clog2(BUSY_CYCLES + 1);

  // ---------------- input filtering ----------------
  logic [1:0] raw_lines;
  logic [1:0] flt_lines;
  assign raw_lines = {scl_i, sda_i};

  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_filt
      i2cm_glitch_filt #(.LEN(FILT_LEN)) u_filt (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_lines[g]),
        .dout (flt_lines[g])
      );
    end
  endgenerate

  logic scl_f, sda_f, scl_p, sda_p;
  assign scl_f = flt_lines[1];
  assign sda_f = flt_lines[0];

  // ---------------- named bus events ----------------
  logic scl_rise, scl_fall, start_ev, stop_ev;
  assign scl_rise = scl_f & ~scl_p;
  assign scl_fall = ~scl_f & scl_p;
  assign start_ev = scl_f & scl_p & sda_p & ~sda_f;
  assign stop_ev  = scl_f & scl_p & ~sda_p & sda_f;

  function automatic logic [AW-1:0] addr_next(input logic [AW-1:0] a);
    return (a == AW'(MEM_DEPTH - 1)) ? '0 : a + 1'b1;
  endfunction

  // ---------------- state ----------------
  slv_state_t    state;
  logic [3:0]    bit_cnt;
  logic          in_ack;
  logic [7:0]    shreg;
  logic [7:0]    txreg;
  logic [AW-1:0] addr;
  logic          mack;
  logic          rw_q;
  logic          wr_pend;
  logic [BW-1:0] busy_cnt;
  logic          oe_q;
  logic [7:0]    rd_data;

  logic busy, byte_rx, ack_end, dev_ok, wr_strobe;
  assign busy      = (busy_cnt != '0);
  assign byte_rx   = scl_fall & ~in_ack & (bit_cnt == 4'd8);
  assign ack_end   = scl_fall & in_ack;
  assign dev_ok    = dev_hit(shreg, dev_sel) & ~busy;
  assign wr_strobe = byte_rx & (state == ST_WDATA) & ~wp & ~start_ev & ~stop_ev;

  i2cm_store #(.DEPTH(MEM_DEPTH), .AW(AW)) u_store (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (wr_strobe),
    .waddr(addr),
    .wdata(shreg),
    .raddr(addr),
    .rdata(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p    <= 1'b1;
      sda_p    <= 1'b1;
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      in_ack   <= 1'b0;
      shreg    <= '0;
      txreg    <= '0;
      addr     <= '0;
      mack     <= 1'b0;
      rw_q     <= 1'b0;
      wr_pend  <= 1'b0;
      busy_cnt <= '0;
      oe_q     <= 1'b0;
    end else begin
      scl_p <= scl_f;
      sda_p <= sda_f;
      if (busy) busy_cnt <= busy_cnt - 1'b1;

      if (start_ev) begin
        state   <= ST_DEV;
        bit_cnt <= '0;
        in_ack  <= 1'b0;
        oe_q    <= 1'b0;
      end else if (stop_ev) begin
        state   <= ST_IDLE;
        in_ack  <= 1'b0;
        oe_q    <= 1'b0;
        if (wr_pend) begin
          busy_cnt <= BW'(BUSY_CYCLES);
          wr_pend  <= 1'b0;
        end
      end else begin
        unique case (state)
          ST_DEV, ST_WADDR, ST_WDATA: begin
            if (scl_rise && !in_ack && bit_cnt < 4'd8) begin
              shreg   <= {shreg[6:0], sda_f};
              bit_cnt <= bit_cnt + 1'b1;
            end
            if (byte_rx) begin
              in_ack <= 1'b1;
              unique case (state)
                ST_DEV: begin
                  oe_q <= dev_ok;
                  rw_q <= shreg[0];
                end
                ST_WADDR: begin
                  addr <= shreg[AW-1:0];
                  oe_q <= 1'b1;
                end
                default: begin
                  oe_q <= 1'b1;
                  addr <= addr_next(addr);
                  if (!wp) wr_pend <= 1'b1;
                end
              endcase
            end
            if (ack_end) begin
              in_ack  <= 1'b0;
              bit_cnt <= '0;
              oe_q    <= 1'b0;
              unique case (state)
                ST_DEV: begin
                  if (!oe_q) begin
                    state <= ST_SKIP;
                  end else if (rw_q) begin
                    state <= ST_RD;
                    txreg <= rd_data;
                    addr  <= addr_next(addr);
                    oe_q  <= ~rd_data[7];
                  end else begin
                    state <= ST_WADDR;
                  end
                end
                ST_WADDR: state <= ST_WDATA;
                default:  state <= ST_WDATA;
              endcase
            end
          end
          ST_RD: begin
            if (scl_rise) begin
              if (in_ack) mack <= ~sda_f;
              else        bit_cnt <= bit_cnt + 1'b1;
            end
            if (scl_fall && !in_ack) begin
              if (bit_cnt == 4'd8) begin
                in_ack <= 1'b1;
                oe_q   <= 1'b0;
              end else begin
                txreg <= {txreg[6:0], 1'b0};
                oe_q  <= ~txreg[6];
              end
            end
            if (ack_end) begin
              in_ack  <= 1'b0;
              bit_cnt <= '0;
              if (mack) begin
                txreg <= rd_data;
                addr  <= addr_next(addr);
                oe_q  <= ~rd_data[7];
              end else begin
                state <= ST_SKIP;
                oe_q  <= 1'b0;
              end
            end
          end
          default: oe_q <= 1'b0;
        endcase
      end
    end
  end

  assign sda_oe = oe_q;
endmodule

// File: rtl/i2cm_chk.sv
module i2cm_chk (
  input logic clk,
  input logic rst_n,
  input logic sda_oe,
  input logic scl_fall,
  input logic start_ev,
  input logic stop_ev,
  input logic busy,
  input logic wr_strobe
);
  AST_OE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall)); // R5
  AST_START_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> !sda_oe); // R2
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_oe); // R3
  AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !$rose(sda_oe)); // R8
  AST_WRITE_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |=> sda_oe); // R6
endmodule

bind i2c_mem_slave i2cm_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sda_oe   (sda_oe),
  .scl_fall (scl_fall),
  .start_ev (start_ev),
  .stop_ev  (stop_ev),
  .busy     (busy),
  .wr_strobe(wr_strobe)
);

// File: tb/i2c_mem_slave_tb.sv
module i2c_mem_slave_tb;
  localparam int FL    = 4;
  localparam int DEPTH = 64;
  localparam int BC    = 2000;
  localparam int H     = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic [2:0] dev_sel = 3'b101;
  logic       wp = 1'b0;
  logic       sda_oe;
  logic       sda;

  int total = 0;
  int bad = 0;
  logic [7:0] model [DEPTH];
  logic [7:0] wbuf [8];

  always #2.5 clk = ~clk;

  assign sda = sda_m & ~sda_oe;

  i2c_mem_slave #(.FILT_LEN(FL), .MEM_DEPTH(DEPTH), .BUSY_CYCLES(BC)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
    .dev_sel(dev_sel), .wp(wp), .sda_oe(sda_oe)
  );

  function automatic logic [7:0] dev_byte(input logic [2:0] sel, input logic rw);
    return {4'b1010, sel, rw};
  endfunction

  function automatic int wrap_inc(input int a);
    return (a + 1) % DEPTH;
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic m_start();
    tick(H/2); sda_m = 1'b1; tick(H/2); scl = 1'b1; tick(H); sda_m = 1'b0; tick(H); scl = 1'b0;
  endtask

  task automatic m_stop();
    tick(H/2); sda_m = 1'b0; tick(H/2); scl = 1'b1; tick(H); sda_m = 1'b1; tick(H);
  endtask

  task automatic m_send(input logic [7:0] b, input int gl, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      tick(H/2); sda_m = b[i]; tick(H/2); scl = 1'b1;
      if (i == gl) begin
        tick(H/2); sda_m = 1'b0; tick(2); sda_m = 1'b1; tick(2);
        scl = 1'b0; tick(2); scl = 1'b1; tick(H/2 - 6);
      end else begin
        tick(H);
      end
      scl = 1'b0;
    end
    tick(H/2); sda_m = 1'b1; tick(H/2); scl = 1'b1; tick(H/2);
    ack = (sda == 1'b0);
    tick(H/2); scl = 1'b0;
  endtask

  task automatic m_recv(input logic mack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      tick(H/2); sda_m = 1'b1; tick(H/2); scl = 1'b1; tick(H/2);
      d[i] = sda;
      tick(H/2); scl = 1'b0;
    end
    tick(H/2); sda_m = ~mack; tick(H/2); scl = 1'b1; tick(H); scl = 1'b0;
  endtask

  task automatic poll(input logic exp_ack, input string req);
    logic ack;
    m_start();
    m_send(dev_byte(dev_sel, 1'b0), -1, ack);
    check(ack == exp_ack, req, ack, exp_ack);
    m_stop();
  endtask

  task automatic wr_txn(input int a, input int n, input int gl);
    logic ack;
    int p;
    m_start();
    m_send(dev_byte(dev_sel, 1'b0), -1, ack);
    check(ack, "R5 device byte ack", ack, 1);
    m_send(8'(a), -1, ack);
    check(ack, "R5 word address ack", ack, 1);
    p = a;
    for (int k = 0; k < n; k++) begin
      m_send(wbuf[k], (k == 0) ? gl : -1, ack);
      check(ack, wp ? "R9 data ack under protect" : "R5 data ack", ack, 1);
      if (!wp) model[p] = wbuf[k];
      p = wrap_inc(p);
    end
    m_stop();
    check(sda_oe == 1'b0, "R3 release after stop", sda_oe, 0);
  endtask

  task automatic rd_txn(input int a, input int n, input string req);
    logic ack;
    logic [7:0] d;
    int p;
    m_start();
    m_send(dev_byte(dev_sel, 1'b0), -1, ack);
    m_send(8'(a), -1, ack);
    m_start();
    m_send(dev_byte(dev_sel, 1'b1), -1, ack);
    check(ack, "R2 repeated start read ack", ack, 1);
    p = a;
    for (int k = 0; k < n; k++) begin
      m_recv(k != n - 1, d);
      check(d == model[p], req, d, model[p]);
      p = wrap_inc(p);
    end
    tick(H/2);
    check(sda_oe == 1'b0, "R7 released after nack", sda_oe, 0);
    m_stop();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int seed;
    int a;
    int n;
    seed = $urandom(32'd4242);
    for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;
    tick(10);
    check(sda_oe == 1'b0, "R3 reset release", sda_oe, 0);
    rst_n = 1'b1;
    tick(20);

    // R4: wrong strap and wrong type code
    poll(1'b1, "R4 matching device byte");
    begin
      logic ack;
      m_start();
      m_send(dev_byte(3'b011, 1'b0), -1, ack);
      check(!ack, "R4 strap mismatch nack", ack, 0);
      m_stop();
      m_start();
      m_send({4'b1011, dev_sel, 1'b0}, -1, ack);
      check(!ack, "R4 type code mismatch nack", ack, 0);
      m_stop();
    end

    // R6 / R8: write then busy polling
    wbuf[0] = 8'h3C; wbuf[1] = 8'hA5; wbuf[2] = 8'h0F;
    wr_txn(5, 3, -1);
    poll(1'b0, "R8 busy nack");
    tick(BC + 100);
    poll(1'b1, "R8 ack after busy");
    rd_txn(5, 3, "R7 sequential read data");

    // R6 wrap at the top of the array
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    wr_txn(DEPTH - 2, 4, -1);
    tick(BC + 100);
    rd_txn(DEPTH - 2, 4, "R6 wrap write and read");

    // R9 write protect
    wp = 1'b1;
    wbuf[0] = 8'hDE; wbuf[1] = 8'hAD;
    wr_txn(5, 2, -1);
    poll(1'b1, "R9 no busy after protected write");
    wp = 1'b0;
    rd_txn(5, 2, "R9 protected data unchanged");

    // R1 spikes on both lines during a data bit
    wbuf[0] = 8'hFF; wbuf[1] = 8'h81;
    wr_txn(20, 2, 3);
    tick(BC + 100);
    rd_txn(20, 2, "R1 spike filtered data");

    // random traffic
    for (int it = 0; it < 6; it++) begin
      dev_sel = 3'($urandom);
      a = int'($urandom % DEPTH);
      n = 1 + int'($urandom % 4);
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
      wr_txn(a, n, -1);
      tick(BC + 100);
      rd_txn(a, n, "R7 random read back");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule